// File: doc/BRIEF.md
# Capture/Compare Timer with Interrupt Flags

This block is a 16-bit free-running counter with two edge-triggered capture channels, two compare registers used in alternation, and one 8-bit control/status register that holds five sticky event flags and three interrupt enables. The counter advances by one on each cycle where the count-enable tick is high. A rising edge on a capture pin stores the counter in that channel's capture register. A match against the compare register that is currently active sets that register's flag and hands the role to the other register. A wrap from FFFFh to 0000h sets the overflow flag.

Software reaches every register through a simple byte-wide port: a single-cycle write strobe, an address and write data, and read data that follows the address combinationally. The interrupt request is a level. It stays high while any enabled source has its flag set, and it drops when software writes that flag to 0.

Top module: `cc_timer_irq`

## Requirements
- R1: After reset the counter reads 0, the control register reads 00h, the interrupt request is low and compare register 1 is the active one.
- R2: The counter (address 1 low byte, address 2 high byte) goes up by one on each clock where tick_i is high. It holds its value when tick_i is low.
- R3: When a tick arrives with the counter at FFFFh, the counter becomes 0000h and control bit 1 (overflow flag) is set.
- R4: A rising edge on cap_i[0] (or cap_i[1]) stores the counter value in capture register 1 at addresses 7/8 (or capture register 2 at addresses 9/10), and sets control bit 6 (or bit 7). A pin that stays high or falls stores nothing.
- R5: When the counter steps onto the value of the active compare register, that register's flag is set: control bit 3 for compare register 1 (addresses 3/4), control bit 4 for compare register 2 (addresses 5/6). A match against the inactive register sets nothing.
- R6: After each match the other compare register becomes the active one.
- R7: A flag stays at 1 until software writes the control register (address 0) with that bit at 0.
- R8: If hardware sets a flag in the same cycle that software writes it to 0, the flag ends up at 1.
- R9: irq_o is high exactly when (bit 6 or bit 7) and bit 5, or (bit 3 or bit 4) and bit 2, or bit 1 and bit 0 of the control register are set.
- R10: The compare registers read back what was written. Writes to the counter or capture addresses leave those registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one increment per high cycle |
| cap_i | input | 2 | Asynchronous capture pins, channel 0 and channel 1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_o | output | 1 | Interrupt request level |

## Verification
A software write of 0 to the control register and a hardware flag set can land on the same clock edge. The bench provokes this by raising tick_i with the counter one below the active compare value, and pulsing the write strobe with data 00h in that same cycle. It then reads the control register and expects the compare-1 flag to be 1, because the hardware set takes priority over the clear.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
    localparam int CNT_W  = 16;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 4;
    localparam int CAP_N  = 2;
    localparam int CMP_N  = 2;
    localparam int BYTES  = CNT_W / BUS_W;

    // control register bit positions, decoded by software
    localparam int F_OVF_IE = 0;
    localparam int F_OVF    = 1;
    localparam int F_CMP_IE = 2;
    localparam int F_CMP0   = 3;
    localparam int F_CAP_IE = 5;
    localparam int F_CAP0   = 6;

    // register map bases
    localparam int A_CTRL     = 0;
    localparam int A_CNT_BASE = 1;
    localparam int A_CMP_BASE = A_CNT_BASE + BYTES;
    localparam int A_CAP_BASE = A_CMP_BASE + CMP_N * BYTES;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [CMP_N-1:0][CNT_W-1:0] cmp;
        logic [CAP_N-1:0][CNT_W-1:0] cap;
        logic [BUS_W-1:0]            ctrl;
    } state_t;
endpackage

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cc_match_sel.sv
module cc_match_sel #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [W-1:0] cnt_next_i,
    input  logic [W-1:0] cmp0_i,
    input  logic [W-1:0] cmp1_i,
    output logic [1:0]   hit_o,
    output logic         sel_o
);
    logic sel_d, sel_q;
    logic [W-1:0] active;

    always_comb begin
        active   = sel_q ? cmp1_i : cmp0_i;
        hit_o    = 2'b00;
        if (tick_i && (cnt_next_i == active)) hit_o[sel_q] = 1'b1;
        sel_d    = sel_q ^ (|hit_o);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sel_q <= 1'b0;
        else         sel_q <= sel_d;
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/cc_timer_irq.sv
module cc_timer_irq
    import cc_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [CAP_N-1:0]  cap_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              irq_o
);
    state_t st_d, st_q;

    logic [CAP_N-1:0] cap_rise;
    logic [CMP_N-1:0] cmp_hit;
    logic             cmp_sel;
    logic [CNT_W-1:0] cnt_inc;
    logic             ovf;

    assign cnt_inc = st_q.cnt + CNT_W'(1);
    assign ovf     = tick_i & (&st_q.cnt);

    for (genvar k = 0; k < CAP_N; k++) begin : g_cap
        cc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (cap_i[k]),
            .rise_o (cap_rise[k])
        );
    end

    cc_match_sel #(.W(CNT_W)) u_match (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .cnt_next_i (cnt_inc),
        .cmp0_i     (st_q.cmp[0]),
        .cmp1_i     (st_q.cmp[1]),
        .hit_o      (cmp_hit),
        .sel_o      (cmp_sel)
    );

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.cnt = cnt_inc;

        if (wr_en_i) begin
            if (addr_i == ADDR_W'(A_CTRL)) st_d.ctrl = wdata_i;
            for (int k = 0; k < CMP_N; k++) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (addr_i == ADDR_W'(A_CMP_BASE + k*BYTES + b))
                        st_d.cmp[k][b*BUS_W +: BUS_W] = wdata_i;
                end
            end
        end

        // hardware sets come after the software write so they win
        if (ovf) st_d.ctrl[F_OVF] = 1'b1;
        for (int k = 0; k < CAP_N; k++) begin
            if (cap_rise[k]) begin
                st_d.cap[k]             = st_q.cnt;
                st_d.ctrl[F_CAP0 + k]   = 1'b1;
            end
        end
        for (int k = 0; k < CMP_N; k++) begin
            if (cmp_hit[k]) st_d.ctrl[F_CMP0 + k] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_CTRL)) rdata_o = st_q.ctrl;
        for (int b = 0; b < BYTES; b++) begin
            if (addr_i == ADDR_W'(A_CNT_BASE + b))
                rdata_o = st_q.cnt[b*BUS_W +: BUS_W];
        end
        for (int k = 0; k < CMP_N; k++) begin
            for (int b = 0; b < BYTES; b++) begin
                if (addr_i == ADDR_W'(A_CMP_BASE + k*BYTES + b))
                    rdata_o = st_q.cmp[k][b*BUS_W +: BUS_W];
            end
        end
        for (int k = 0; k < CAP_N; k++) begin
            for (int b = 0; b < BYTES; b++) begin
                if (addr_i == ADDR_W'(A_CAP_BASE + k*BYTES + b))
                    rdata_o = st_q.cap[k][b*BUS_W +: BUS_W];
            end
        end
    end

    assign irq_o = ((|st_q.ctrl[F_CAP0 +: CAP_N]) & st_q.ctrl[F_CAP_IE])
                 | ((|st_q.ctrl[F_CMP0 +: CMP_N]) & st_q.ctrl[F_CMP_IE])
                 | (st_q.ctrl[F_OVF] & st_q.ctrl[F_OVF_IE]);
endmodule

// File: rtl/cc_timer_irq_chk.sv
module cc_timer_irq_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        tick_i,
    input logic        wr_en_i,
    input logic [3:0]  addr_i,
    input logic [7:0]  wdata_i,
    input logic [15:0] cnt,
    input logic [7:0]  ctrl,
    input logic [1:0]  rise,
    input logic [1:0]  hit,
    input logic        sel,
    input logic        irq_o
);
    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && cnt != 16'hFFFF) |=> cnt == 16'($past(cnt) + 16'd1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(cnt));

    // R3
    ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && cnt == 16'hFFFF) |=> (ctrl[1] && cnt == 16'h0000));

    // R4
    cap0_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise[0] |=> ctrl[6]);

    // R4
    cap1_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise[1] |=> ctrl[7]);

    // R5
    hit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit));

    // R6
    sel_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|hit) |=> sel != $past(sel));

    // R6
    sel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|hit) |=> $stable(sel));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl[1] && !(wr_en_i && addr_i == 4'd0 && !wdata_i[1])) |=> ctrl[1]);

    // R9
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl[5] && !ctrl[2] && !ctrl[0]) |-> !irq_o);
endmodule

bind cc_timer_irq cc_timer_irq_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cnt     (st_q.cnt),
    .ctrl    (st_q.ctrl),
    .rise    (cap_rise),
    .hit     (cmp_hit),
    .sel     (cmp_sel),
    .irq_o   (irq_o)
);

// File: tb/sim_cc_timer_irq.sv
`timescale 1ns/1ps
module sim_cc_timer_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cap = 2'b00;
    logic       wr = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cc_timer_irq u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cap_i(cap),
        .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd8(input logic [3:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd8(a, lo); rd8(a + 4'd1, hi); d = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] c; logic [15:0] v;
        rd8(4'd0, c);  chk("R1 ctrl", 16'(c), 16'h0000);
        rd16(4'd1, v); chk("R1 counter", v, 16'h0000);
        chk("R1 irq", 16'(irq), 16'h0000);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr_reg(4'd3, 8'h34); wr_reg(4'd4, 8'h12);
        wr_reg(4'd5, 8'hCD); wr_reg(4'd6, 8'hAB);
        rd16(4'd3, v); chk("R10 cmp1 readback", v, 16'h1234);
        rd16(4'd5, v); chk("R10 cmp2 readback", v, 16'hABCD);
        wr_reg(4'd7, 8'h55); wr_reg(4'd2, 8'h77);
        rd16(4'd7, v); chk("R10 capture write ignored", v, 16'h0000);
        rd16(4'd1, v); chk("R10 counter write ignored", v, 16'h0000);
    endtask

    task automatic t_count;
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rd16(4'd1, v); chk("R2 hold without tick", v, 16'd0);
        ticks(10);
        rd16(4'd1, v); chk("R2 ten ticks", v, 16'd10);
    endtask

    task automatic t_capture;
        logic [15:0] v; logic [7:0] c;
        @(negedge clk); cap[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd16(4'd7, v); chk("R4 capture 1 value", v, 16'd10);
        rd8(4'd0, c);  chk("R4 capture flags", 16'(c[7:6]), 16'h1);
        ticks(5);
        @(negedge clk); cap[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd16(4'd7, v); chk("R4 high/fall no relatch", v, 16'd10);
        @(negedge clk); cap[1] = 1'b1;
        repeat (4) @(negedge clk);
        cap[1] = 1'b0;
        rd16(4'd9, v); chk("R4 capture 2 value", v, 16'd15);
        rd8(4'd0, c);  chk("R4 capture flag 2", 16'(c[7:6]), 16'h3);
        chk("R9 irq off with enables low", 16'(irq), 16'h0);
        wr_reg(4'd0, 8'hE0);
        chk("R9 capture irq", 16'(irq), 16'h1);
        wr_reg(4'd0, 8'h20);
        rd8(4'd0, c);  chk("R7 flags cleared by 0", 16'(c), 16'h20);
        chk("R9 irq drops after clear", 16'(irq), 16'h0);
        wr_reg(4'd0, 8'h00);
    endtask

    task automatic t_compare;
        logic [7:0] c;
        wr_reg(4'd3, 8'd20); wr_reg(4'd4, 8'd0);
        wr_reg(4'd5, 8'd18); wr_reg(4'd6, 8'd0);
        ticks(3);   // counter 18, compare 2 inactive
        rd8(4'd0, c); chk("R5 inactive register ignored", 16'(c[4:3]), 16'h0);
        ticks(2);   // counter 20
        rd8(4'd0, c); chk("R5 compare 1 match", 16'(c[4:3]), 16'h1);
        wr_reg(4'd5, 8'd25);
        ticks(5);   // counter 25, compare 2 now active
        rd8(4'd0, c); chk("R6 compare 2 active after match", 16'(c[4:3]), 16'h3);
        repeat (3) @(negedge clk);
        rd8(4'd0, c); chk("R7 compare flags sticky", 16'(c[4:3]), 16'h3);
        wr_reg(4'd0, 8'h1C);
        chk("R9 compare irq", 16'(irq), 16'h1);
        wr_reg(4'd0, 8'h00);
    endtask

    task automatic t_collide;
        logic [7:0] c;
        wr_reg(4'd3, 8'd30);
        ticks(4);   // counter 29, compare 1 active
        rd8(4'd0, c); chk("R5 no early flag", 16'(c), 16'h00);
        @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 4'd0; wdata = 8'h00;
        @(negedge clk); tick = 1'b0; wr = 1'b0;
        rd8(4'd0, c); chk("R8 set beats clear", 16'(c[3]), 16'h1);
        wr_reg(4'd0, 8'h00);
    endtask

    task automatic t_overflow;
        logic [15:0] v; logic [7:0] c;
        wr_reg(4'd0, 8'h01);
        ticks(65535 - 30);
        rd16(4'd1, v); chk("R2 counter at top", v, 16'hFFFF);
        rd8(4'd0, c);  chk("R3 no flag before wrap", 16'(c[1]), 16'h0);
        chk("R9 no irq before wrap", 16'(irq), 16'h0);
        ticks(1);
        rd16(4'd1, v); chk("R3 wrap to zero", v, 16'h0000);
        rd8(4'd0, c);  chk("R3 overflow flag", 16'(c[1]), 16'h1);
        chk("R9 overflow irq", 16'(irq), 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count();
        t_capture();
        t_compare();
        t_collide();
        t_overflow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule